// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Flag Unit

This block watches 24 general-purpose input pins, split into three groups, and raises a sticky flag for a group whenever any pin in that group changes level, rising or falling. Group 0 covers pins 7..0. Group 1 covers pins 14..8. Group 2 covers pins 23..16. Pin 15 belongs to no group.

Each flag drives an interrupt request for its group. A request is passed on only when the group's enable bit and the global interrupt-enable input are also set. A flag clears in two ways: when software writes a 1 to its bit, or when the CPU pulses the acknowledge line for that group as it enters the vector.

Software reaches the flag register and the group-enable register over a simple register bus. The bus has an address, a write strobe, write data and combinational read data.

Top module: `pcint_group_flags`

## Requirements
- R1: A level change on any of pins 7..0 sets flag bit 0. The flag reads as set at the third rising clock edge after the pin changes (two synchroniser stages, then one edge-detect register).
- R2: A level change on any of pins 14..8 sets flag bit 1. A change on pin 15 sets no flag.
- R3: A level change on any of pins 23..16 sets flag bit 2.
- R4: Request `irq[g]` is high exactly when flag bit g, enable bit g and `gie` are all 1.
- R5: A one-cycle pulse on `ack[g]` clears flag bit g and leaves the other flags unchanged.
- R6: Writing to the flag address (default 0x3B) clears each flag bit whose write-data bit is 1. A write-data bit of 0 leaves that flag unchanged.
- R7: After reset, the flag register and the enable register both read 0x00, and all `irq` outputs are low.
- R8: Bits 7..3 of both registers always read 0 and ignore writes. The enable register is at its own address (default 0x3C), with bit g enabling group g.
- R9: If a group's pin change and a clear of that flag (write-1 or acknowledge) occur in the same cycle, the flag ends up set.
- R10: A read from any address other than the two register addresses returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | 24 | Asynchronous pin inputs |
| gie | input | 1 | Global interrupt enable |
| ack | input | 3 | Per-group vector acknowledge pulse |
| addr | input | ADDR_W | Register bus address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 3 | Per-group interrupt request |

## Verification
The hardest case to reach from the ports is the set-wins collision of R9. The edge-detect result exists only inside the block, for one cycle, two edges after the pin toggles. The bench toggles a pin at a falling edge and counts exactly two rising edges. It then drives the clear, either a write-1 or an acknowledge, so that it lands on the same edge as the internal change pulse, and reads the flag back to confirm it survived. A plain clear with no pin activity is run around it, to show that the same stimulus on its own does clear the flag.

// File: rtl/pcint_group_flags.sv
module pcint_group_flags #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h3B,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [23:0]       pins,
  input  logic              gie,
  input  logic [2:0]        ack,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [2:0]        irq
);
  localparam logic [23:0] G0_MASK = 24'h0000FF;
  localparam logic [23:0] G1_MASK = 24'h007F00;
  localparam logic [23:0] G2_MASK = 24'hFF0000;
  localparam logic [7:0]  LIVE    = 8'h07;

  logic [23:0] s1, s2, prev;
  logic [7:0]  flag_q, ena_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1 <= pins; s2 <= s1; prev <= s2;
    end

  wire [23:0] chg = s2 ^ prev;
  wire [2:0]  hit = {|(chg & G2_MASK), |(chg & G1_MASK), |(chg & G0_MASK)};

  wire       wr_flag = wr_en && (addr == FLAG_ADDR);
  wire       wr_ena  = wr_en && (addr == ENA_ADDR);
  wire [7:0] clr     = (wr_flag ? (wr_data & LIVE) : 8'h00) | {5'b0, ack};
  wire [7:0] flag_d  = ((flag_q & ~clr) | {5'b0, hit}) & LIVE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_q <= '0;
      ena_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_ena) ena_q <= wr_data & LIVE;
    end

  assign irq = flag_q[2:0] & ena_q[2:0] & {3{gie}};

  always_comb begin
    if (addr == FLAG_ADDR)     rd_data = flag_q;
    else if (addr == ENA_ADDR) rd_data = ena_q;
    else                       rd_data = 8'h00;
  end

  p_set_g0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg & G0_MASK)) |=> flag_q[0]);
  p_set_g1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg & G1_MASK)) |=> flag_q[1]);
  p_set_g2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg & G2_MASK)) |=> flag_q[2]);
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> gie);
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[7:3] == 5'b0) && (ena_q[7:3] == 5'b0));

  for (genvar g = 0; g < 3; g++) begin : g_chk
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && !hit[g]) |=> !flag_q[g]);
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && wr_data[g] && !hit[g]) |=> !flag_q[g]);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !ack[g] && !(wr_flag && wr_data[g])) |=> flag_q[g]);
  end
endmodule

// File: tb/pcint_group_flags_test.sv
`timescale 1ns/1ps
module pcint_group_flags_test;
  localparam logic [7:0] FA = 8'h3B;
  localparam logic [7:0] EA = 8'h3C;

  logic clk = 0, rst_n = 0, gie = 0, wr_en = 0;
  logic [23:0] pins = '0;
  logic [2:0] ack = '0;
  logic [7:0] addr = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] irq;
  int checks = 0, errors = 0;
  logic [7:0] v;

  pcint_group_flags uut (.clk, .rst_n, .pins, .gie, .ack, .addr, .wr_en,
                         .wr_data, .rd_data, .irq);

  always #2.5 clk = ~clk;

  // {toggle mask, expected flags}
  localparam logic [26:0] VEC [10] = '{
    {24'h000001, 3'b001}, {24'h000001, 3'b001},
    {24'h008000, 3'b000}, {24'h008000, 3'b000},
    {24'h000100, 3'b010}, {24'h004000, 3'b010},
    {24'h800000, 3'b100}, {24'h010000, 3'b100},
    {24'h010001, 3'b101}, {24'h804001, 3'b111}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic toggle(logic [23:0] m);
    @(negedge clk); pins = pins ^ m;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R7 reset state
    rd(FA, v); chk("R7 flag reset", v, 8'h00);
    rd(EA, v); chk("R7 enable reset", v, 8'h00);
    chk("R7 irq reset", {5'b0, irq}, 8'h00);

    // R1 R2 R3 table: rising and falling edges, pin 15, several groups
    for (int i = 0; i < 10; i++) begin
      toggle(VEC[i][26:3]);
      rd(FA, v); chk($sformatf("R1/R2/R3 vec %0d", i), v, {5'b0, VEC[i][2:0]});
      wr(FA, 8'hFF);
      rd(FA, v); chk($sformatf("R6 clear vec %0d", i), v, 8'h00);
    end

    // R8 unused bits
    wr(FA, 8'hF8); rd(FA, v); chk("R8 flag upper", v, 8'h00);
    wr(EA, 8'hFF); rd(EA, v); chk("R8 enable upper", v, 8'h07);
    // R10 other address
    rd(8'h00, v); chk("R10 other addr", v, 8'h00);

    // R4 gating
    toggle(24'h000002);
    gie = 0; #1 chk("R4 gie low", {5'b0, irq}, 8'h00);
    gie = 1; #1 chk("R4 all enabled", {5'b0, irq}, 8'h01);
    wr(EA, 8'h06); #1 chk("R4 group disabled", {5'b0, irq}, 8'h00);
    wr(EA, 8'h07); #1 chk("R4 re-enabled", {5'b0, irq}, 8'h01);

    // R6 write 0 no effect, write 1 clears
    wr(FA, 8'h00); rd(FA, v); chk("R6 write zero", v, 8'h01);
    wr(FA, 8'h01); rd(FA, v); chk("R6 write one", v, 8'h00);

    // R5 acknowledge clears only its group
    toggle(24'h000202);
    rd(FA, v); chk("R5 pre-ack", v, 8'h03);
    @(negedge clk) ack = 3'b010;
    @(negedge clk) ack = 3'b000;
    rd(FA, v); chk("R5 ack group1", v, 8'h01);
    chk("R5 irq after ack", {5'b0, irq}, 8'h01);
    @(negedge clk) ack = 3'b001;
    @(negedge clk) ack = 3'b000;
    rd(FA, v); chk("R5 ack group0", v, 8'h00);

    // R9 set wins over write-1
    toggle(24'h000004);
    @(negedge clk) pins = pins ^ 24'h000004;
    @(posedge clk); @(posedge clk);
    wr(FA, 8'h01);
    rd(FA, v); chk("R9 set beats write", v, 8'h01);
    wr(FA, 8'h01); rd(FA, v); chk("R9 plain write clears", v, 8'h00);

    // R9 set wins over acknowledge
    toggle(24'h400000);
    @(negedge clk) pins = pins ^ 24'h400000;
    @(posedge clk); @(posedge clk);
    @(negedge clk) ack = 3'b100;
    @(negedge clk) ack = 3'b000;
    rd(FA, v); chk("R9 set beats ack", v, 8'h04);
    @(negedge clk) ack = 3'b100;
    @(negedge clk) ack = 3'b000;
    rd(FA, v); chk("R9 plain ack clears", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule